// File: doc/BRIEF.md
# ADC Result Accumulator and Formatter

This block sits between an ADC conversion engine and the register that software reads. Each conversion hands it a 12-bit unsigned code with a one-cycle valid strobe. In single-sample mode every code goes straight into a 16-bit result register. The code is placed either at the bottom of the word (right-justified) or at the top (left-justified), and every bit the code does not occupy is zero.

In accumulate mode a series of 4, 8 or 16 codes is summed. The result register is written only once, when the last code of the series arrives. The written value is the full unsigned sum, always right-justified, so the meaningful width grows to 14, 15 or 16 bits. The result is presented as a high byte and a low byte, and a one-cycle ready pulse marks each load.

Top module: `adc_result_acc`

## Requirements
- R1: `rpt_sel` selects the series length: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 16 samples.
- R2: With `rpt_sel` = 2'b00, every valid sample loads the result register at the clock edge that samples `smp_vld`.
- R3: In single-sample mode with `just_left` = 0, the result is the code in bits 11:0, and bits 15:12 are zero (mid-scale 0x800 gives 0x0800).
- R4: In single-sample mode with `just_left` = 1, the result is the code in bits 15:4, and bits 3:0 are zero (0xFFF gives 0xFFF0, 0x7FF gives 0x7FF0).
- R5: In accumulate mode, intermediate samples leave the result register unchanged. The sum of all N samples is loaded at the edge that takes the Nth valid sample (4 × 0x7FF gives 0x1FFC).
- R6: Accumulated results are right-justified whatever `just_left` is (16 × 0xFFF gives 0xFFF0). A sum of 4 fits in bits 13:0 and a sum of 8 fits in bits 14:0.
- R7: If `rpt_sel` differs from its value in the previous cycle, the partial series is discarded. A valid sample in that same cycle counts as the first sample of a new series of the new length.
- R8: `res_rdy` is high for exactly the cycles that follow a result load, and low otherwise.
- R9: After reset the result reads 0x0000, `res_rdy` is low, and no samples are pending.
- R10: `res_hi` carries result bits 15:8 and `res_lo` carries bits 7:0.
- R11: While `smp_vld` is low, `smp_code` has no effect on the result or on the series progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: `smp_code` holds a new conversion |
| smp_code | input | 12 | Unsigned conversion code |
| just_left | input | 1 | Left-justify request (single-sample mode only) |
| rpt_sel | input | 2 | Series length select |
| res_hi | output | 8 | Result bits 15:8 |
| res_lo | output | 8 | Result bits 7:0 |
| res_rdy | output | 1 | Pulses when the result register is loaded |

## Verification
A change of the series length can fall in the same cycle as a valid sample. The sample in that cycle must then start the new series rather than finish or extend the old one. The bench provokes this on purpose: it switches `rpt_sel` mid-series together with a strobe, and it also does so at random during a long mixed run. A behavioural model with its own counter and running sum is compared against the ports on every clock. Back-to-back single-sample loads, which keep `res_rdy` high for consecutive cycles, are exercised the same way.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

   localparam int RPT_SEL_W = 2;

   typedef enum logic [RPT_SEL_W-1:0] {
      RPT_X1  = 2'b00,
      RPT_X4  = 2'b01,
      RPT_X8  = 2'b10,
      RPT_X16 = 2'b11
   } rpt_sel_e;

   // Number of samples per series for a select code: 1, then powers of two from 4.
   function automatic int rpt_len(input logic [RPT_SEL_W-1:0] sel);
      if (sel == '0) return 1;
      return 1 << (int'(sel) + 1);
   endfunction

   localparam int MAX_RPT = 1 << ((1 << RPT_SEL_W));

endpackage

// File: rtl/adc_acc_series_ctrl.sv
module adc_acc_series_ctrl
   import adc_acc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic [RPT_SEL_W-1:0] rpt_sel,
   output logic                 restart,
   output logic                 last
);

   logic [RPT_SEL_W-1:0] sel_q;
   logic [CNT_W-1:0]     cnt_q, cnt_d, cnt_eff, cnt_lim;

   always_comb begin
      restart = (rpt_sel != sel_q);
      cnt_eff = restart ? '0 : cnt_q;
      cnt_lim = CNT_W'(rpt_len(rpt_sel) - 1);
      last    = smp_vld && (cnt_eff == cnt_lim);
      if (last)         cnt_d = '0;
      else if (smp_vld) cnt_d = cnt_eff + 1'b1;
      else              cnt_d = cnt_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         sel_q <= rpt_sel;
         cnt_q <= cnt_d;
      end
   end

   // R1: progress never reaches the series length of the held select
   a_r1_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < rpt_len(sel_q));

   // R11: without a strobe and with a steady select, progress holds
   a_r11_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/adc_acc_sum.sv
module adc_acc_sum #(
   parameter int SAMPLE_W = 12,
   parameter int SUM_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_code,
   input  logic                restart,
   input  logic                last,
   output logic [SUM_W-1:0]    total
);

   logic [SUM_W-1:0] acc_q, base, code_ext;

   generate
      if (SUM_W > SAMPLE_W) begin : g_ext
         assign code_ext = {{(SUM_W-SAMPLE_W){1'b0}}, smp_code};
      end else begin : g_same
         assign code_ext = smp_code;
      end
   endgenerate

   always_comb begin
      base  = restart ? '0 : acc_q;
      total = base + code_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= '0;
      else if (smp_vld)  acc_q <= last ? '0 : total;
      else if (restart)  acc_q <= '0;
   end

   // R5: a finished series leaves nothing behind
   a_r5_clear_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (acc_q == '0));

endmodule

// File: rtl/adc_acc_fmt.sv
module adc_acc_fmt
   import adc_acc_pkg::*;
#(
   parameter int SAMPLE_W   = 12,
   parameter int OUT_W      = 16,
   parameter bit LEFT_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 last,
   input  logic [RPT_SEL_W-1:0] rpt_sel,
   input  logic                 just_left,
   input  logic [SAMPLE_W-1:0]  smp_code,
   input  logic [OUT_W-1:0]     total,
   output logic [OUT_W-1:0]     result,
   output logic                 ready
);

   localparam int PAD_W = OUT_W - SAMPLE_W;

   logic [OUT_W-1:0] right_val, left_val, load_val;

   assign right_val = total;

   generate
      if (LEFT_EN) begin : g_left
         assign left_val = {smp_code, {PAD_W{1'b0}}};
      end else begin : g_noleft
         assign left_val = right_val;
      end
   endgenerate

   always_comb begin
      if ((rpt_sel == RPT_X1) && just_left) load_val = left_val;
      else                                   load_val = right_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         ready  <= 1'b0;
      end else begin
         ready <= last;
         if (last) result <= load_val;
      end
   end

   // R8: the result only moves together with the ready pulse
   a_r8_move_with_ready : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> ready);

endmodule

// File: rtl/adc_result_acc.sv
module adc_result_acc
   import adc_acc_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int BYTE_W   = 8,
   parameter bit LEFT_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic [SAMPLE_W-1:0]  smp_code,
   input  logic                 just_left,
   input  logic [RPT_SEL_W-1:0] rpt_sel,
   output logic [BYTE_W-1:0]    res_hi,
   output logic [BYTE_W-1:0]    res_lo,
   output logic                 res_rdy
);

   localparam int OUT_W   = 2 * BYTE_W;
   localparam int CNT_W   = $clog2(MAX_RPT);
   localparam int GROWTH  = $clog2(MAX_RPT);

   generate
      if (OUT_W < SAMPLE_W + GROWTH) begin : g_bad_width
         $error("result width too small for the largest accumulated sum");
      end
      if (SAMPLE_W < 1) begin : g_bad_sample
         $error("sample width must be positive");
      end
   endgenerate

   logic             restart, last;
   logic [OUT_W-1:0] total, result;

   adc_acc_series_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .rpt_sel (rpt_sel),
      .restart (restart),
      .last    (last)
   );

   adc_acc_sum #(.SAMPLE_W(SAMPLE_W), .SUM_W(OUT_W)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_vld  (smp_vld),
      .smp_code (smp_code),
      .restart  (restart),
      .last     (last),
      .total    (total)
   );

   adc_acc_fmt #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W), .LEFT_EN(LEFT_EN)) u_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .last      (last),
      .rpt_sel   (rpt_sel),
      .just_left (just_left),
      .smp_code  (smp_code),
      .total     (total),
      .result    (result),
      .ready     (res_rdy)
   );

   assign res_hi = result[OUT_W-1:BYTE_W];
   assign res_lo = result[BYTE_W-1:0];

   // R3: right-justified single loads leave the top bits clear
   a_r3_right_top_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (res_rdy && $past(rpt_sel == RPT_X1 && !just_left)) |-> (result[OUT_W-1:SAMPLE_W] == '0));

   // R4: left-justified single loads leave the bottom bits clear
   a_r4_left_low_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (res_rdy && $past(rpt_sel == RPT_X1 && just_left)) |-> (result[OUT_W-SAMPLE_W-1:0] == '0));

   // R6: a four-sample sum never reaches the top two bits
   a_r6_x4_width : assert property (@(posedge clk) disable iff (!rst_n)
      (res_rdy && $past(rpt_sel == RPT_X4)) |-> (result[OUT_W-1:SAMPLE_W+2] == '0));

endmodule

// File: tb/sim_adc_result_acc.sv
`timescale 1ns/1ps
module sim_adc_result_acc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [11:0] smp_code = '0;
   logic        just_left = 1'b0;
   logic [1:0]  rpt_sel = 2'b00;
   logic [7:0]  res_hi, res_lo;
   logic        res_rdy;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   string phase_tag = "R9";

   always #2.5 clk = ~clk;

   adc_result_acc u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
      .just_left(just_left), .rpt_sel(rpt_sel),
      .res_hi(res_hi), .res_lo(res_lo), .res_rdy(res_rdy)
   );

   // behavioural reference
   int    m_cnt = 0, m_acc = 0, m_res = 0, m_psel = 0;
   bit    m_rdy = 0;
   string m_tag = "R9";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_acc = 0; m_res = 0; m_psel = 0; m_rdy = 0; m_tag = "R9";
      end else begin
         int len;
         len = (rpt_sel == 0) ? 1 : (1 << (int'(rpt_sel) + 1)); // R1 encoding
         if (int'(rpt_sel) != m_psel) begin m_cnt = 0; m_acc = 0; end // R7
         m_psel = int'(rpt_sel);
         m_rdy = 0;
         m_tag = phase_tag;
         if (smp_vld) begin
            m_acc += int'(smp_code);
            m_cnt++;
            if (m_cnt == len) begin
               if (rpt_sel == 0) begin
                  m_res = just_left ? (int'(smp_code) << 4) : int'(smp_code);
                  m_tag = just_left ? "R4" : "R3";
               end else begin
                  m_res = m_acc;
                  m_tag = "R6";
               end
               m_rdy = 1; m_acc = 0; m_cnt = 0;
            end
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // compare on every clock, away from the rising edge; R10 byte split
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk({m_tag, "/R10 hi"}, int'(res_hi), (m_res >> 8) & 8'hFF);
         chk({m_tag, "/R10 lo"}, int'(res_lo), m_res & 8'hFF);
         chk("R8 ready", int'(res_rdy), int'(m_rdy));
      end
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   task automatic push(int code);
      @(negedge clk); smp_vld = 1'b1; smp_code = 12'(code);
      @(negedge clk); smp_vld = 1'b0; smp_code = 12'hA5A;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 hi", int'(res_hi), 0);
      chk("R9 lo", int'(res_lo), 0);
      chk("R9 ready", int'(res_rdy), 0);
      rst_n = 1'b1;
      idle(2);

      // R2 / R3 single right-justified codes
      phase_tag = "R2";
      push(12'hFFF); push(12'h800); push(12'h7FF); push(12'h000);
      // R4 left-justified
      just_left = 1'b1;
      push(12'hFFF); push(12'h800); push(12'h7FF); push(12'h000);
      // R2/R8 back-to-back single loads
      @(negedge clk); smp_vld = 1; smp_code = 12'h123;
      @(negedge clk); smp_code = 12'h456;
      @(negedge clk); smp_vld = 0;
      idle(1);

      // R11: garbage with strobe low has no effect
      phase_tag = "R11";
      for (int i = 0; i < 6; i++) begin @(negedge clk); smp_code = 12'(i * 777); end

      // R5 / R6: four of 0x7FF with justify set -> 0x1FFC
      phase_tag = "R5";
      @(negedge clk); rpt_sel = 2'b01; idle(1);
      for (int i = 0; i < 4; i++) push(12'h7FF);
      // R6: sixteen full-scale -> 0xFFF0
      @(negedge clk); rpt_sel = 2'b11; idle(1);
      for (int i = 0; i < 16; i++) push(12'hFFF);
      // eight with gaps
      @(negedge clk); rpt_sel = 2'b10; just_left = 0; idle(1);
      for (int i = 0; i < 8; i++) begin push(12'h800 + i); idle(i % 3); end

      // R7: abort mid-series, change coincides with a strobe
      phase_tag = "R7";
      @(negedge clk); rpt_sel = 2'b01; idle(1);
      push(12'h100); push(12'h200);
      @(negedge clk); rpt_sel = 2'b10; smp_vld = 1; smp_code = 12'h011;
      @(negedge clk); smp_vld = 0;
      for (int i = 0; i < 7; i++) push(12'h001);
      // change to single mode mid-series with strobe
      push(12'h300);
      @(negedge clk); rpt_sel = 2'b00; smp_vld = 1; smp_code = 12'h0AB;
      @(negedge clk); smp_vld = 0;
      idle(2);

      // mixed random run
      phase_tag = "R1";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         smp_vld   = ($urandom % 3) != 0;
         smp_code  = 12'($urandom);
         if (($urandom % 40) == 0) rpt_sel = 2'($urandom);
         if (($urandom % 25) == 0) just_left = ~just_left;
      end
      @(negedge clk); smp_vld = 0;
      idle(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule